// File: doc/BRIEF.md
# Per-CPU Doorbell Interrupt Unit

This unit gives each CPU of a small cluster (four by default) two doorbell interrupts. The "other" doorbell lets one CPU signal another. The "self" doorbell lets a CPU, or a supervisor using an explicit view, post an event to that CPU. Each doorbell has a pending bit and a mask bit. Software reaches them through a register window with two parts. The first is a self-relative part, whose registers always act on the CPU making the access. The second is a set of explicit per-CPU aliases that act on a chosen CPU whatever the accessor.

Each CPU drains its events by reading its event register. A pending doorbell that is not masked wins the read. It is returned with a dedicated type code and is masked in the same cycle, so it is not delivered twice before software acknowledges it and unmasks it. If no doorbell is ready, the read passes on the hardware-line event that the per-CPU arbiter offers, and pulses a take strobe back to that arbiter. The unit also drives a per-CPU doorbell request level toward the arbiter.

Top module: `ipi_doorbell_unit`

## Requirements
- R1: After reset, no doorbell is pending and both doorbells of every CPU are masked. A read of a pending register returns 0x00000000, a read of a mask register returns 0x80000001, and db_req and rsp_valid are low.
- R2: A read of offset 0x000 returns the accessing CPU's index, zero-extended.
- R3: A write to offset 0x008 (send) sets the "other" doorbell (bit 0) pending on CPU c for each set data bit c < NCPU. Data bit 31 sets the accessor's own "self" doorbell. Data bits from NCPU to 30 have no effect.
- R4: A write to offset 0x00C clears, for each data bit set among bit 0 ("other") and bit 31 ("self"), that pending bit of the accessor. A read of 0x00C returns the accessor's pending word, with "other" in bit 0 and "self" in bit 31.
- R5: Writes to offset 0x010 set, and writes to offset 0x014 clear, the accessor's mask bits selected by data bits 0 and 31. A read of either offset returns the accessor's mask word.
- R6: The explicit view of CPU c sits at 0x100 + c*0x80. Offset +0x0 sets pending bits, +0x4 clears pending bits, +0x8 sets mask bits and +0xC clears mask bits, all on CPU c whatever the accessor. Reads at +0x0 or +0x4 return CPU c's pending word, and reads at +0x8 or +0xC return its mask word.
- R7: db_req[c] is high exactly when CPU c has at least one doorbell that is both pending and unmasked.
- R8: A read of offset 0x004 (event) returns 0x00040001 when "other" is pending and unmasked. Otherwise it returns 0x00040002 when "self" is pending and unmasked. The delivered doorbell's mask bit becomes set, and its pending bit is kept.
- R9: When no doorbell of the accessor is deliverable, an event read returns hw_evt_word of that CPU and pulses hw_evt_take for it in the request cycle, provided hw_evt_valid is high for that CPU. Otherwise it returns 0. A deliverable doorbell always wins over the hardware line, and hw_evt_take stays low in that case.
- R10: Every read gives rsp_valid exactly one cycle after the request, together with rsp_data. A read of any unmapped offset returns 0, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the accessing CPU |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| hw_evt_valid | input | NCPU | Hardware-line event offered per CPU |
| hw_evt_word | input | NCPU*32 | Hardware-line event word per CPU |
| hw_evt_take | output | NCPU | Hardware-line event consumed by an event read |
| db_req | output | NCPU | Doorbell pending and unmasked, per CPU |

## Verification
Each access has results due at three different times. The take strobe is combinational, so it is sampled 1 ns after the request is driven on the falling edge, before the rising edge. The pending and mask state, and with it db_req, change at the rising edge that accepts the request. Read data also registers at that edge. For these two, the bench samples rsp_valid, rsp_data and db_req on the following falling edge, against a reference model that has already applied the access. Event reads are issued back to back on one CPU. This shows that auto-masking takes effect in time for the very next read to see the lower-priority source.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BIT_OTHER = 0;
  localparam int unsigned BIT_SELF  = 31;

  localparam logic [7:0]  EVT_TYPE_DOORBELL = 8'd4;
  localparam logic [15:0] EVT_NUM_OTHER     = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF      = 16'd2;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_WHOAMI,
    OP_EVENT,
    OP_SEND,
    OP_PEND_SET,
    OP_PEND_CLR,
    OP_MASK_SET,
    OP_MASK_CLR
  } op_e;

  // Internal pair layout: index 0 = other, index 1 = self
  function automatic logic [WORD_W-1:0] pair_to_word(input logic [1:0] p);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[BIT_OTHER] = p[0];
    w[BIT_SELF]  = p[1];
    return w;
  endfunction

  function automatic logic [1:0] word_to_pair(input logic [WORD_W-1:0] w);
    return {w[BIT_SELF], w[BIT_OTHER]};
  endfunction

  function automatic logic [WORD_W-1:0] doorbell_event(input logic [15:0] num);
    return {8'd0, EVT_TYPE_DOORBELL, num};
  endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int unsigned NCPU        = 4,
  parameter int unsigned CPU_W       = 2,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PCPU_BASE   = 'h100,
  parameter int unsigned PCPU_STRIDE = 'h80
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output op_e               op,
  output logic [CPU_W-1:0]  tgt_cpu
);

  localparam int unsigned STRIDE_SH = $clog2(PCPU_STRIDE);
  localparam int unsigned PCPU_END  = PCPU_BASE + NCPU * PCPU_STRIDE;

  // self-relative view
  localparam logic [ADDR_W-1:0] LOC_WHOAMI = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] LOC_EVENT  = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] LOC_SEND   = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] LOC_ACK    = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] LOC_MSET   = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] LOC_MCLR   = ADDR_W'('h014);

  // explicit per-CPU view, offsets within one stride
  localparam logic [STRIDE_SH-1:0] PC_SET  = STRIDE_SH'('h0);
  localparam logic [STRIDE_SH-1:0] PC_CLR  = STRIDE_SH'('h4);
  localparam logic [STRIDE_SH-1:0] PC_MSET = STRIDE_SH'('h8);
  localparam logic [STRIDE_SH-1:0] PC_MCLR = STRIDE_SH'('hC);

  logic [ADDR_W-1:0]    rel;
  logic [CPU_W-1:0]     slot;
  logic [STRIDE_SH-1:0] off;
  logic                 in_pcpu;
  logic                 cpu_ok;

  always_comb begin
    rel     = req_addr - ADDR_W'(PCPU_BASE);
    slot    = CPU_W'(rel >> STRIDE_SH);
    off     = rel[STRIDE_SH-1:0];
    in_pcpu = (32'(req_addr) >= PCPU_BASE) && (32'(req_addr) < PCPU_END);
    cpu_ok  = (32'(req_cpu) < NCPU);
  end

  always_comb begin
    op      = OP_NONE;
    tgt_cpu = req_cpu;
    if (req_valid && cpu_ok) begin
      if (in_pcpu) begin
        tgt_cpu = slot;
        case (off)
          PC_SET:  op = OP_PEND_SET;
          PC_CLR:  op = OP_PEND_CLR;
          PC_MSET: op = OP_MASK_SET;
          PC_MCLR: op = OP_MASK_CLR;
          default: op = OP_NONE;
        endcase
      end else begin
        case (req_addr)
          LOC_WHOAMI: op = req_write ? OP_NONE : OP_WHOAMI;
          LOC_EVENT:  op = req_write ? OP_NONE : OP_EVENT;
          LOC_SEND:   op = req_write ? OP_SEND : OP_NONE;
          LOC_ACK:    op = OP_PEND_CLR;
          LOC_MSET:   op = OP_MASK_SET;
          LOC_MCLR:   op = OP_MASK_CLR;
          default:    op = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        set_pend,
  input  logic [1:0]        clr_pend,
  input  logic [1:0]        set_mask,
  input  logic [1:0]        clr_mask,
  input  logic              evt_rd,
  input  logic              hw_valid,
  input  logic [WORD_W-1:0] hw_word,
  output logic [1:0]        pend,
  output logic [1:0]        mask,
  output logic [WORD_W-1:0] evt_word,
  output logic              hw_take,
  output logic              db_req
);

  logic [1:0] ready;
  logic       pick_other;
  logic       pick_self;
  logic [1:0] auto_mask;
  logic [1:0] pend_d;
  logic [1:0] mask_d;
  logic       pend_en;
  logic       mask_en;

  // priority and delivery
  always_comb begin
    ready      = pend & ~mask;
    pick_other = ready[0];
    pick_self  = ready[1] & ~ready[0];
    auto_mask  = evt_rd ? {pick_self, pick_other} : 2'b00;
    hw_take    = evt_rd & ~(|ready) & hw_valid;
    db_req     = |ready;
    if (pick_other)     evt_word = doorbell_event(EVT_NUM_OTHER);
    else if (pick_self) evt_word = doorbell_event(EVT_NUM_SELF);
    else if (hw_valid)  evt_word = hw_word;
    else                evt_word = '0;
  end

  // next state
  always_comb begin
    pend_en = (|set_pend) | (|clr_pend);
    mask_en = (|set_mask) | (|clr_mask) | (|auto_mask);
    pend_d  = (pend | set_pend) & ~clr_pend;
    mask_d  = (mask | set_mask | auto_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'b00;
      mask <= 2'b11;
    end else begin
      if (pend_en) pend <= pend_d;
      if (mask_en) mask <= mask_d;
    end
  end

  AST_AUTO_MASK_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && pend[0] && !mask[0]) |=> mask[0]) else $error("auto-mask other"); // R8
  AST_EVENT_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !(|set_pend) && !(|clr_pend)) |=> $stable(pend)) else $error("pend kept"); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend != 2'b00) |=> ((pend & $past(clr_pend)) == 2'b00)) else $error("ack clears"); // R4
  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != 2'b00 && clr_mask == 2'b00) |=> ((mask & $past(set_mask)) == $past(set_mask)))
    else $error("mask set"); // R5
  AST_HW_TAKE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |-> (evt_word == hw_word)) else $error("hw take word"); // R9

endmodule

// File: rtl/ipi_doorbell_unit.sv
module ipi_doorbell_unit
  import ipi_pkg::*;
#(
  parameter int unsigned NCPU        = 4,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PCPU_BASE   = 'h100,
  parameter int unsigned PCPU_STRIDE = 'h80,
  localparam int unsigned CPU_W      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [CPU_W-1:0]       req_cpu,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [WORD_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [WORD_W-1:0]      rsp_data,
  input  logic [NCPU-1:0]        hw_evt_valid,
  input  logic [NCPU*WORD_W-1:0] hw_evt_word,
  output logic [NCPU-1:0]        hw_evt_take,
  output logic [NCPU-1:0]        db_req
);

  op_e              op;
  logic [CPU_W-1:0] tgt_cpu;
  logic [1:0]       wpair;

  logic [1:0]        pend_a [NCPU];
  logic [1:0]        mask_a [NCPU];
  logic [WORD_W-1:0] evt_a  [NCPU];

  logic              rd_req;
  logic [WORD_W-1:0] rd_d;
  logic              rsp_valid_d;

  ipi_addr_decode #(
    .NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W),
    .PCPU_BASE(PCPU_BASE), .PCPU_STRIDE(PCPU_STRIDE)
  ) u_decode (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_cpu  (req_cpu),
    .req_addr (req_addr),
    .op       (op),
    .tgt_cpu  (tgt_cpu)
  );

  assign wpair = word_to_pair(req_wdata);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic       sel;
    logic       is_me;
    logic [1:0] set_pend;
    logic [1:0] clr_pend;
    logic [1:0] set_mask;
    logic [1:0] clr_mask;
    logic       evt_rd;

    always_comb begin
      sel      = (tgt_cpu == CPU_W'(c));
      is_me    = (req_cpu == CPU_W'(c));
      set_pend = 2'b00;
      clr_pend = 2'b00;
      set_mask = 2'b00;
      clr_mask = 2'b00;
      evt_rd   = 1'b0;
      if (op == OP_SEND) begin
        set_pend[0] = req_wdata[c];
        set_pend[1] = req_wdata[BIT_SELF] & is_me;
      end
      if (req_write && sel) begin
        if (op == OP_PEND_SET) set_pend = wpair;
        if (op == OP_PEND_CLR) clr_pend = wpair;
        if (op == OP_MASK_SET) set_mask = wpair;
        if (op == OP_MASK_CLR) clr_mask = wpair;
      end
      if (op == OP_EVENT && sel) evt_rd = 1'b1;
    end

    ipi_cpu_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_pend(set_pend),
      .clr_pend(clr_pend),
      .set_mask(set_mask),
      .clr_mask(clr_mask),
      .evt_rd  (evt_rd),
      .hw_valid(hw_evt_valid[c]),
      .hw_word (hw_evt_word[c*WORD_W +: WORD_W]),
      .pend    (pend_a[c]),
      .mask    (mask_a[c]),
      .evt_word(evt_a[c]),
      .hw_take (hw_evt_take[c]),
      .db_req  (db_req[c])
    );
  end

  // read data mux
  always_comb begin
    rd_req      = req_valid & ~req_write;
    rsp_valid_d = rd_req;
    case (op)
      OP_WHOAMI:                rd_d = WORD_W'(req_cpu);
      OP_EVENT:                 rd_d = evt_a[tgt_cpu];
      OP_PEND_SET, OP_PEND_CLR: rd_d = req_write ? '0 : pair_to_word(pend_a[tgt_cpu]);
      OP_MASK_SET, OP_MASK_CLR: rd_d = req_write ? '0 : pair_to_word(mask_a[tgt_cpu]);
      default:                  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rd_req) rsp_data <= rd_d;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid) else $error("read response late"); // R10
  AST_RSP_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid) else $error("spurious response"); // R10
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hw_evt_take)) else $error("multiple takes"); // R9
  AST_TAKE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_evt_take & ~hw_evt_valid) == '0)) else $error("take without line"); // R9

endmodule

// File: tb/tb_ipi_doorbell_unit.sv
`timescale 1ns/1ps
module tb_ipi_doorbell_unit;

  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_cpu;
  logic [9:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [NCPU-1:0]    hw_evt_valid;
  logic [NCPU*32-1:0] hw_evt_word;
  logic [NCPU-1:0]    hw_evt_take;
  logic [NCPU-1:0]    db_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference: [cpu][0]=other, [cpu][1]=self
  bit mp [NCPU][2];
  bit mm [NCPU][2];

  always #2 clk = ~clk;

  ipi_doorbell_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .hw_evt_valid(hw_evt_valid), .hw_evt_word(hw_evt_word),
    .hw_evt_take(hw_evt_take), .db_req(db_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(input bit o, input bit s);
    logic [31:0] w = '0;
    w[0] = o; w[31] = s;
    return w;
  endfunction

  function automatic logic [3:0] model_req();
    logic [3:0] v;
    for (int c = 0; c < NCPU; c++) v[c] = (mp[c][0] && !mm[c][0]) || (mp[c][1] && !mm[c][1]);
    return v;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic access(input bit wr, input int cpu, input int addr,
                        input logic [31:0] d, input string req);
    logic [31:0] exp_rd;
    logic [3:0]  exp_take;
    int t, off;
    exp_rd = '0; exp_take = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_cpu = 2'(cpu);
    req_addr = 10'(addr); req_wdata = d;
    if (addr < 'h100) begin
      case (addr)
        'h000: if (!wr) exp_rd = 32'(cpu);
        'h004: if (!wr) begin
          if (mp[cpu][0] && !mm[cpu][0]) begin exp_rd = 32'h0004_0001; mm[cpu][0] = 1; end
          else if (mp[cpu][1] && !mm[cpu][1]) begin exp_rd = 32'h0004_0002; mm[cpu][1] = 1; end
          else if (hw_evt_valid[cpu]) begin exp_rd = hw_evt_word[cpu*32 +: 32]; exp_take[cpu] = 1; end
        end
        'h008: if (wr) begin
          for (int c = 0; c < NCPU; c++) if (d[c]) mp[c][0] = 1;
          if (d[31]) mp[cpu][1] = 1;
        end
        'h00C: if (wr) begin if (d[0]) mp[cpu][0] = 0; if (d[31]) mp[cpu][1] = 0; end
               else exp_rd = pw(mp[cpu][0], mp[cpu][1]);
        'h010: if (wr) begin if (d[0]) mm[cpu][0] = 1; if (d[31]) mm[cpu][1] = 1; end
               else exp_rd = pw(mm[cpu][0], mm[cpu][1]);
        'h014: if (wr) begin if (d[0]) mm[cpu][0] = 0; if (d[31]) mm[cpu][1] = 0; end
               else exp_rd = pw(mm[cpu][0], mm[cpu][1]);
        default: ;
      endcase
    end else if (addr < 'h100 + NCPU*'h80) begin
      t = (addr - 'h100) / 'h80;
      off = (addr - 'h100) % 'h80;
      case (off)
        'h0: if (wr) begin if (d[0]) mp[t][0] = 1; if (d[31]) mp[t][1] = 1; end
             else exp_rd = pw(mp[t][0], mp[t][1]);
        'h4: if (wr) begin if (d[0]) mp[t][0] = 0; if (d[31]) mp[t][1] = 0; end
             else exp_rd = pw(mp[t][0], mp[t][1]);
        'h8: if (wr) begin if (d[0]) mm[t][0] = 1; if (d[31]) mm[t][1] = 1; end
             else exp_rd = pw(mm[t][0], mm[t][1]);
        'hC: if (wr) begin if (d[0]) mm[t][0] = 0; if (d[31]) mm[t][1] = 0; end
             else exp_rd = pw(mm[t][0], mm[t][1]);
        default: ;
      endcase
    end
    #1;
    chk(hw_evt_take == exp_take, req, "hw_evt_take", 32'(hw_evt_take), 32'(exp_take));
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(rsp_valid == !wr, req, "rsp_valid", 32'(rsp_valid), 32'(!wr));
    if (!wr) chk(rsp_data == exp_rd, req, $sformatf("rsp_data @%h", addr), rsp_data, exp_rd);
    chk(db_req == model_req(), req, "db_req", 32'(db_req), 32'(model_req()));
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_cpu = 0; req_addr = 0; req_wdata = 0;
    hw_evt_valid = 0; hw_evt_word = 0;
    for (int c = 0; c < NCPU; c++) begin mp[c][0] = 0; mp[c][1] = 0; mm[c][0] = 1; mm[c][1] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(db_req == 0, "R1", "db_req after reset", 32'(db_req), 0);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    for (int c = 0; c < NCPU; c++) begin
      access(0, c, 'h00C, 0, "R1");
      access(0, c, 'h010, 0, "R1");
    end
    // R2: who-am-I
    for (int c = 0; c < NCPU; c++) access(0, c, 'h000, 0, "R2");
    // R3: send to CPUs 1 and 2; high bits beyond NCPU ignored
    access(1, 0, 'h008, 32'h0000_0F06, "R3");
    access(0, 1, 'h00C, 0, "R3");
    access(0, 0, 'h00C, 0, "R3");
    access(0, 3, 'h00C, 0, "R3");
    // R5/R7: unmask other on CPU1 raises db_req
    access(1, 1, 'h014, 32'h0000_0001, "R5");
    access(0, 1, 'h014, 0, "R5");
    // R8: event read, auto-mask, pending kept
    access(0, 1, 'h004, 0, "R8");
    access(0, 1, 'h00C, 0, "R8");
    access(0, 1, 'h004, 0, "R9");
    // R4: acknowledge
    access(1, 1, 'h00C, 32'h8000_0001, "R4");
    access(0, 1, 'h00C, 0, "R4");
    // R6: explicit view of CPU2 from CPU0
    access(1, 0, 'h200, 32'h8000_0000, "R6");
    access(0, 3, 'h200, 0, "R6");
    access(1, 0, 'h20C, 32'h8000_0001, "R6");
    access(0, 0, 'h208, 0, "R6");
    // R8: back-to-back event reads, other before self
    hw_evt_valid[2] = 1; hw_evt_word[2*32 +: 32] = 32'h0001_0033;
    access(0, 2, 'h004, 0, "R8");
    access(0, 2, 'h004, 0, "R8");
    access(0, 2, 'h004, 0, "R9");
    hw_evt_valid[2] = 0;
    access(0, 2, 'h004, 0, "R9");
    // R9: hardware line on CPU3, then doorbell wins
    hw_evt_valid[3] = 1; hw_evt_word[3*32 +: 32] = 32'h0001_0005;
    access(0, 3, 'h004, 0, "R9");
    access(1, 3, 'h008, 32'h8000_0000, "R3");
    access(1, 3, 'h014, 32'h8000_0000, "R7");
    access(0, 3, 'h004, 0, "R9");
    access(0, 3, 'h004, 0, "R9");
    hw_evt_valid[3] = 0;
    // R6: clear via explicit view, mask set via explicit view
    access(1, 1, 'h384 - 'h100, 32'h8000_0001, "R6");
    access(1, 2, 'h188, 32'h8000_0001, "R6");
    access(0, 2, 'h18C, 0, "R6");
    // R10: unmapped offsets
    access(1, 0, 'h040, 32'hFFFF_FFFF, "R10");
    access(0, 0, 'h040, 0, "R10");
    access(1, 0, 'h300, 32'h8000_0001, "R10");
    access(0, 0, 'h300, 0, "R10");
    access(1, 1, 'h000, 32'hFFFF_FFFF, "R10");
    access(0, 1, 'h008, 0, "R10");
    for (int c = 0; c < NCPU; c++) access(0, c, 'h00C, 0, "R10");
    summary();
  end

endmodule